// File: doc/BRIEF.md
# Auto-Reload Timer with Prescaler

This block is an 8-bit up-counter that advances on a count tick formed from a base-rate enable. A two-bit source select first picks either every base enable or every third one. A free-running power-of-two prescaler then thins those source ticks further. On each count tick the counter steps up by one. When it steps past FFh it takes the value held in a reload register instead of wrapping to zero.

Software reaches the block through a synchronous register bus: address, write strobe, write data and combinational read data. A compare register sets a sticky match flag whenever the counter holds the compare value on a tick. A sticky overflow flag records each rollover. A load window reads the live counter and can overwrite it without stopping it. The counter keeps its value through reset, so a value written before a reset can still be read after it.

Top module: `arTimer`

## Requirements
- R1: The control register at address E7h holds a 3-bit prescale code in bits 7:5. The counter advances once every 2^code source ticks, so code 000 gives every tick and code 111 gives one tick in 128.
- R2: Control bits 1:0 select the source. 00 means every cycle with `baseEn` high. 01 means every third cycle with `baseEn` high. Codes 10 and 11 give no source ticks, so the counter holds.
- R3: A write to the prescale code does not clear the prescaler's running count. The new ratio applies to the count already accumulated.
- R4: A count tick that finds the counter at FFh loads the reload register (address E9h) into the counter.
- R5: Address EBh reads the current counter value. A write to EBh sets the counter on the next clock edge, whether or not it is counting.
- R6: The counter and load value are not cleared by reset. A value written before reset reads back unchanged after reset.
- R7: A count tick that finds the counter equal to the compare register (address EAh) sets the sticky compare flag. The flag is visible on `cmpFlag` and in status bit 1 at address E8h.
- R8: A count tick that finds the counter at FFh sets the sticky overflow flag. The flag is visible on `ovfFlag` and in status bit 0. Writing 1 to a status bit clears that flag. If a set and a clear fall in the same cycle, the set wins.
- R9: Control bits 4:2 always read as zero. Any address other than E7h to EBh reads as zero.
- R10: If a load write and an overflow reload fall on the same edge, the counter takes the written value. The overflow flag is still set.
- R11: After reset, control, reload, compare and both flags read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseEn | input | 1 | Single-cycle enable at the base count rate |
| addr | input | 8 | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| ovfFlag | output | 1 | Sticky overflow flag |
| cmpFlag | output | 1 | Sticky compare-match flag |

## Verification
The assertions assume that `baseEn` and every bus input change only between clock edges and hold steady across each edge. They also assume that the counter has been written at least once before its value is relied on, because it has no reset value. The stimulus drives all inputs one time unit after the rising edge. It writes the load register before it checks any counter value, and it leaves the counter unchecked until that first write. Random stretches vary `baseEn` and issue writes to any mapped address, including flag clears that can land on the same edge as a flag set.

// File: rtl/arTimerPkg.sv
package arTimerPkg;
  localparam int DATA_W = 8;
  localparam int PSC_W  = 3;
  localparam int SRC_W  = 2;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] CTL_ADDR  = 8'hE7;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'hE8;
  localparam logic [ADDR_W-1:0] REL_ADDR  = 8'hE9;
  localparam logic [ADDR_W-1:0] CMP_ADDR  = 8'hEA;
  localparam logic [ADDR_W-1:0] LOAD_ADDR = 8'hEB;

  // Control to datapath: strobes and configuration
  typedef struct packed {
    logic              ldWr;
    logic [DATA_W-1:0] ldData;
    logic [PSC_W-1:0]  psSel;
    logic [SRC_W-1:0]  srcSel;
    logic [DATA_W-1:0] reloadVal;
    logic [DATA_W-1:0] cmpVal;
  } ctlStrobe_t;

  // Datapath to control: single-cycle events
  typedef struct packed {
    logic ovfEv;
    logic cmpEv;
  } tmrEvent_t;
endpackage

// File: rtl/arTimerDatapath.sv
module arTimerDatapath
  import arTimerPkg::*;
#(
  parameter int CNT_W = DATA_W,
  parameter int PS_W  = PSC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baseEn,
  input  ctlStrobe_t       ctlS,
  output tmrEvent_t        evtS,
  output logic [CNT_W-1:0] cntVal,
  output logic             cntTick
);
  localparam int PS_CNT_W = (1 << PS_W) - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]          div3Q;
  logic                srcTick;
  logic [PS_CNT_W-1:0] psCntQ;
  logic [PS_CNT_W-1:0] psMask;
  logic [CNT_W-1:0]    cntQ;

  // Modulo-3 enable divider, advancing on every base enable
  always_ff @(posedge clk) begin
    if (!rstN) div3Q <= '0;
    else if (baseEn) div3Q <= (div3Q == 2'd2) ? 2'd0 : div3Q + 2'd1;
  end

  always_comb begin
    case (ctlS.srcSel)
      2'b00:   srcTick = baseEn;
      2'b01:   srcTick = baseEn && (div3Q == 2'd2);
      default: srcTick = 1'b0;
    endcase
  end

  // Free-running prescaler; the select only picks the mask
  always_ff @(posedge clk) begin
    if (!rstN) psCntQ <= '0;
    else if (srcTick) psCntQ <= psCntQ + 1'b1;
  end

  assign psMask  = ~({PS_CNT_W{1'b1}} << ctlS.psSel);
  assign cntTick = rstN && srcTick && ((psCntQ & psMask) == psMask);

  // Counter has no reset: it holds its value across reset
  always_ff @(posedge clk) begin
    if (rstN) begin
      if (ctlS.ldWr) cntQ <= ctlS.ldData;
      else if (cntTick) cntQ <= (cntQ == CNT_MAX) ? ctlS.reloadVal : cntQ + 1'b1;
    end
  end

  assign evtS.ovfEv = cntTick && (cntQ == CNT_MAX);
  assign evtS.cmpEv = cntTick && (cntQ == ctlS.cmpVal);
  assign cntVal     = cntQ;
endmodule

// File: rtl/arTimerCtrl.sv
module arTimerCtrl
  import arTimerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] cntVal,
  input  tmrEvent_t         evtS,
  output ctlStrobe_t        ctlS,
  output logic [DATA_W-1:0] rdData,
  output logic              ovfFlag,
  output logic              cmpFlag
);
  logic [PSC_W-1:0]  psSelQ;
  logic [SRC_W-1:0]  srcSelQ;
  logic [DATA_W-1:0] reloadQ, cmpQ;
  logic              ovfQ, cmpFQ;
  logic              ctlWr, statWr, relWr, cmpWr, ldWr;

  assign ctlWr  = wrEn && (addr == CTL_ADDR);
  assign statWr = wrEn && (addr == STAT_ADDR);
  assign relWr  = wrEn && (addr == REL_ADDR);
  assign cmpWr  = wrEn && (addr == CMP_ADDR);
  assign ldWr   = wrEn && (addr == LOAD_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psSelQ  <= '0;
      srcSelQ <= '0;
      reloadQ <= '0;
      cmpQ    <= '0;
      ovfQ    <= 1'b0;
      cmpFQ   <= 1'b0;
    end else begin
      if (ctlWr) begin
        psSelQ  <= wrData[DATA_W-1 -: PSC_W];
        srcSelQ <= wrData[SRC_W-1:0];
      end
      if (relWr) reloadQ <= wrData;
      if (cmpWr) cmpQ <= wrData;
      // set has priority over write-one-to-clear
      ovfQ  <= evtS.ovfEv | (ovfQ  & ~(statWr & wrData[0]));
      cmpFQ <= evtS.cmpEv | (cmpFQ & ~(statWr & wrData[1]));
    end
  end

  always_comb begin
    ctlS.ldWr      = ldWr;
    ctlS.ldData    = wrData;
    ctlS.psSel     = psSelQ;
    ctlS.srcSel    = srcSelQ;
    ctlS.reloadVal = reloadQ;
    ctlS.cmpVal    = cmpQ;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      CTL_ADDR: begin
        rdData[DATA_W-1 -: PSC_W] = psSelQ;
        rdData[SRC_W-1:0]         = srcSelQ;
      end
      STAT_ADDR: rdData[1:0] = {cmpFQ, ovfQ};
      REL_ADDR:  rdData = reloadQ;
      CMP_ADDR:  rdData = cmpQ;
      LOAD_ADDR: rdData = cntVal;
      default:   rdData = '0;
    endcase
  end

  assign ovfFlag = ovfQ;
  assign cmpFlag = cmpFQ;
endmodule

// File: rtl/arTimer.sv
module arTimer
  import arTimerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              ovfFlag,
  output logic              cmpFlag
);
  ctlStrobe_t        ctlS;
  tmrEvent_t         evtS;
  logic [DATA_W-1:0] cntVal;
  logic              cntTick;

  arTimerCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .cntVal(cntVal), .evtS(evtS), .ctlS(ctlS), .rdData(rdData),
    .ovfFlag(ovfFlag), .cmpFlag(cmpFlag)
  );

  arTimerDatapath #(.CNT_W(DATA_W), .PS_W(PSC_W)) dp_i (
    .clk(clk), .rstN(rstN), .baseEn(baseEn), .ctlS(ctlS), .evtS(evtS),
    .cntVal(cntVal), .cntTick(cntTick)
  );
endmodule

// File: rtl/arTimerChk.sv
module arTimerChk
  import arTimerPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              ovfFlag,
  input logic              cmpFlag,
  input logic              cntTick,
  input logic [DATA_W-1:0] cntVal,
  input logic [DATA_W-1:0] reloadVal,
  input logic [DATA_W-1:0] cmpVal,
  input logic [SRC_W-1:0]  srcSel
);
  logic ldWrite, atMax, unmapped;
  assign ldWrite  = wrEn && (addr == LOAD_ADDR);
  assign atMax    = (cntVal == '1);
  assign unmapped = (addr < CTL_ADDR) || (addr > LOAD_ADDR);

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr == CTL_ADDR) |-> (rdData[4:2] == 3'b000)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    unmapped |-> (rdData == '0)); // R9
  AST_NO_RSV_TICK: assert property (@(posedge clk) disable iff (!rstN)
    srcSel[1] |-> !cntTick); // R2
  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (cntTick && atMax && !ldWrite) |=> (cntVal == $past(reloadVal))); // R4
  AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ldWrite |=> (cntVal == $past(wrData))); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ldWrite && cntTick && atMax) |=> (cntVal == $past(wrData))); // R10
  AST_CMP_SET: assert property (@(posedge clk) disable iff (!rstN)
    (cntTick && (cntVal == cmpVal)) |=> cmpFlag); // R7
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    (cntTick && atMax) |=> ovfFlag); // R8
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(wrEn && (addr == STAT_ADDR) && wrData[0])) |=> ovfFlag); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cntTick && !ldWrite) |=> $stable(cntVal)); // R5
endmodule

bind arTimer arTimerChk chk_i (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag), .cntTick(cntTick),
  .cntVal(cntVal), .reloadVal(ctlS.reloadVal), .cmpVal(ctlS.cmpVal),
  .srcSel(ctlS.srcSel)
);

// File: tb/arTimer_tb_top.sv
module arTimer_tb_top;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_CTL = 8'hE7, A_STAT = 8'hE8, A_REL = 8'hE9,
                         A_CMP = 8'hEA, A_LOAD = 8'hEB;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseEn = 1'b0;
  logic [7:0] addr = A_STAT;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       ovfFlag, cmpFlag;

  int    nChk = 0, nFail = 0;
  bit    done = 1'b0;
  string curReq = "R11";

  // reference state
  int mDiv3 = 0, mPs = 0, mCnt = 0, mPsSel = 0, mSrc = 0;
  int mRel = 0, mCmp = 0, mOvf = 0, mCf = 0;
  bit mCntKnown = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  arTimer dut_i (
    .clk(clk), .rstN(rstN), .baseEn(baseEn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag)
  );

  function automatic int mRead(input int a);
    case (a)
      A_CTL:   return (mPsSel << 5) | mSrc;
      A_STAT:  return (mCf << 1) | mOvf;
      A_REL:   return mRel;
      A_CMP:   return mCmp;
      A_LOAD:  return mCnt;
      default: return 0;
    endcase
  endfunction

  // behavioural reference, one step per clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      mDiv3 = 0; mPs = 0; mPsSel = 0; mSrc = 0; mRel = 0; mCmp = 0; mOvf = 0; mCf = 0;
    end else begin
      bit src, tick, setO, setC;
      int nxt, period;
      src = (mSrc == 0) ? baseEn : ((mSrc == 1) ? (baseEn && mDiv3 == 2) : 1'b0);
      if (baseEn) mDiv3 = (mDiv3 + 1) % 3;
      period = 1 << mPsSel;
      tick = src && ((mPs % period) == period - 1);
      if (src) mPs = (mPs + 1) % 128;
      setO = tick && (mCnt == 255);
      setC = tick && (mCnt == mCmp);
      nxt = mCnt;
      if (tick) nxt = (mCnt == 255) ? mRel : mCnt + 1;
      if (wrEn) begin
        case (addr)
          A_CTL:  begin mPsSel = wrData >> 5; mSrc = wrData & 3; end
          A_STAT: begin
            if (wrData[0]) mOvf = 0;
            if (wrData[1]) mCf = 0;
          end
          A_REL:  mRel = wrData;
          A_CMP:  mCmp = wrData;
          A_LOAD: begin nxt = wrData; mCntKnown = 1'b1; end
          default: ;
        endcase
      end
      if (setO) mOvf = 1;
      if (setC) mCf = 1;
      mCnt = nxt;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    nChk++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // compare with the reference every cycle, mid-period
  always @(negedge clk) begin
    if (rstN && !done) begin
      check({curReq, " ovfFlag"}, ovfFlag, mOvf);
      check({curReq, " cmpFlag"}, cmpFlag, mCf);
      if (addr != A_LOAD || mCntKnown) check({curReq, " rdData"}, rdData, mRead(addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0; addr = A_STAT;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input int exp);
    addr = a;
    @(negedge clk);
    check(req, rdData, exp);
    @(posedge clk); #1;
    addr = A_STAT;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int held;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    curReq = "R11";
    rdChk("R11 control", A_CTL, 0);
    rdChk("R11 reload", A_REL, 0);
    rdChk("R11 compare", A_CMP, 0);
    rdChk("R11 status", A_STAT, 0);

    curReq = "R5";
    wr(A_LOAD, 8'h00);
    wr(A_CTL, 8'h00);
    baseEn = 1'b1;
    run(10);
    baseEn = 1'b0;
    rdChk("R5 live count", A_LOAD, 10);

    curReq = "R9";
    wr(A_CTL, 8'hFF);
    rdChk("R9 reserved bits", A_CTL, 8'hE3);
    rdChk("R9 unmapped low", 8'h00, 0);
    rdChk("R9 unmapped high", 8'hEC, 0);
    wr(A_CTL, 8'h00);

    curReq = "R4";
    wr(A_STAT, 8'h03);
    wr(A_REL, 8'hF0);
    wr(A_LOAD, 8'hFD);
    baseEn = 1'b1;
    run(3);
    baseEn = 1'b0;
    rdChk("R4 reload", A_LOAD, 8'hF0);
    rdChk("R8 overflow set", A_STAT, 1);
    curReq = "R8";
    wr(A_STAT, 8'h01);
    rdChk("R8 overflow cleared", A_STAT, 0);

    curReq = "R7";
    wr(A_CMP, 8'hF5);
    baseEn = 1'b1;
    run(5);
    baseEn = 1'b0;
    rdChk("R7 no early match", A_STAT, 0);
    baseEn = 1'b1;
    run(1);
    baseEn = 1'b0;
    rdChk("R7 match", A_STAT, 2);
    wr(A_STAT, 8'h02);

    curReq = "R1";
    for (int code = 0; code < 8; code++) begin
      wr(A_CTL, 8'(code << 5));
      baseEn = 1'b1;
      run(300);
      baseEn = 1'b0;
    end

    curReq = "R3";
    baseEn = 1'b1;
    wr(A_CTL, 8'h60);
    run(5);
    wr(A_CTL, 8'h40);
    run(20);
    wr(A_CTL, 8'h20);
    run(7);
    baseEn = 1'b0;

    curReq = "R2";
    wr(A_CTL, 8'h01);
    for (int i = 0; i < 90; i++) begin
      baseEn = ($urandom_range(0, 3) != 0);
      run(1);
    end
    baseEn = 1'b0;
    wr(A_LOAD, 8'h40);
    wr(A_CTL, 8'h02);
    baseEn = 1'b1;
    run(30);
    wr(A_CTL, 8'h03);
    run(30);
    baseEn = 1'b0;
    rdChk("R2 reserved source holds", A_LOAD, 8'h40);

    curReq = "R10";
    wr(A_CTL, 8'h00);
    wr(A_STAT, 8'h03);
    baseEn = 1'b1;
    wr(A_LOAD, 8'hFF);
    wr(A_LOAD, 8'h33);
    baseEn = 1'b0;
    rdChk("R10 load beats reload", A_LOAD, 8'h33);
    rdChk("R10 overflow still flagged", A_STAT, 1);

    curReq = "R8";
    for (int i = 0; i < 3000; i++) begin
      baseEn = ($urandom_range(0, 1) != 0);
      if ($urandom_range(0, 9) == 0) begin
        logic [7:0] a, d;
        a = 8'(A_CTL + $urandom_range(0, 4));
        d = 8'($urandom_range(0, 255));
        if (a == A_CTL) d = d & 8'hE1;
        wr(a, d);
      end else run(1);
    end
    baseEn = 1'b0;

    curReq = "R6";
    wr(A_LOAD, 8'h5A);
    held = 8'h5A;
    rstN = 1'b0;
    run(3);
    rstN = 1'b1;
    rdChk("R6 counter kept over reset", A_LOAD, held);
    rdChk("R11 control after reset", A_CTL, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      nChk++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end
endmodule